// File: doc/BRIEF.md
# USB Device Interrupt Status Aggregator

This block keeps the interrupt status byte of a USB device controller. The serial engine sends it single-cycle event pulses for these conditions: start of frame, bus reset, suspend, end of suspend, error, and transfer completion. Each pulse latches a sticky status bit. Only hardware can set these bits. Software clears a bit by writing a zero to its position, and a one written to a position leaves that bit as it was.

The top bit is a correct-transfer summary. It is not stored. It is the live OR of the control endpoint's correct-transfer flag and the receive and transmit correct-transfer flags of every other endpoint. It falls only when all of those flags have been cleared in the endpoint registers, which are outside this block.

A setup overrun occurs when a SETUP transfer completes correctly on the control endpoint while that endpoint's correct-transfer flag is still pending. The block records this in a sticky bit. It also withholds the update strobe for the separate transfer-info register, so that register keeps the details of the transfer software has not yet serviced. A mask register chooses which status bits drive the single interrupt request line.

Top module: `usb_irq_status_agg`

## Requirements
- R1: After a synchronous active-low reset the status byte reads 00h, the mask reads 00h and `irq` is 0.
- R2: A pulse on `ev_sof`, `ev_bus_reset`, `ev_resume`, `ev_suspend` or `ev_error` sets status bit 0, 1, 2, 3 or 4 respectively, visible from the clock edge that samples the pulse. The bit then holds until software clears it.
- R3: A write (`st_wr` high) clears each of status bits 5:0 whose `st_wdata` bit is 0. Bits whose `st_wdata` bit is 1 keep their value, so a write can never set a bit.
- R4: When a hardware set and a software clear reach the same bit in the same cycle, the bit ends up set.
- R5: Status bit 7 is the combinational OR of `ep0_ctr`, every bit of `epn_rx_ctr` and every bit of `epn_tx_ctr`. Writes have no effect on it.
- R6: Status bit 6 always reads 0.
- R7: A cycle with `xfer_done`, `xfer_setup` and `ep0_ctr` all high sets status bit 5 (setup overrun) at the next edge. A SETUP completion while `ep0_ctr` is low leaves bit 5 unchanged.
- R8: `info_upd` is high in exactly those cycles where `xfer_done` is high and no setup overrun condition (R7) is present.
- R9: `irq` is the OR over all eight positions of status AND mask. The mask is loaded whole from `mask_wdata` when `mask_wr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ev_sof | input | 1 | Start-of-frame event pulse |
| ev_bus_reset | input | 1 | Bus reset event pulse |
| ev_resume | input | 1 | End-of-suspend event pulse |
| ev_suspend | input | 1 | Suspend event pulse |
| ev_error | input | 1 | Transfer error event pulse |
| xfer_done | input | 1 | A correct transfer completed this cycle |
| xfer_setup | input | 1 | The completed transfer was a SETUP on the control endpoint |
| ep0_ctr | input | 1 | Control endpoint correct-transfer flag, pending level |
| epn_rx_ctr | input | NUM_EP | Receive correct-transfer flags of the other endpoints |
| epn_tx_ctr | input | NUM_EP | Transmit correct-transfer flags of the other endpoints |
| st_wr | input | 1 | Status write strobe |
| st_wdata | input | 8 | Status write data; a 0 clears bits 5:0 |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | 8 | Mask write data |
| status | output | 8 | Status byte |
| mask | output | 8 | Mask register |
| info_upd | output | 1 | Update strobe for the transfer-info register |
| irq | output | 1 | Combined interrupt request |

## Verification
The sticky bits are tried with all 64 combinations of event pulses. Each combination is followed by a clearing write whose data partly overlaps the set bits, which separates a correct clear-on-zero from a clear-on-one and from a software set. The summary bit is swept over all 128 combinations of endpoint flags, with a clearing write in the same cycle to confirm writes cannot reach it. All eight combinations of completion, SETUP and pending flag are applied to separate an overrun from a normal setup, both for bit 5 and for the update strobe. All 256 mask values are applied against two complementary status patterns to check that every position contributes to `irq` on its own.

// File: rtl/usb_isr_pkg.sv
// Package: shared bit positions of the interrupt status byte.
// Assumes: an 8-bit status byte with the summary bit at the top.
package usb_isr_pkg;
    localparam int STW       = 8;  // status byte width
    localparam int STICKY_W  = 6;  // number of sticky, software-cleared bits
    localparam int B_SOF     = 0;
    localparam int B_BUSRST  = 1;
    localparam int B_RESUME  = 2;
    localparam int B_SUSPEND = 3;
    localparam int B_ERROR   = 4;
    localparam int B_OVR     = 5;
    localparam int B_ZERO    = 6;
    localparam int B_CTR     = 7;
endpackage

// File: rtl/usb_isr_flag.sv
// Module: one sticky status bit, set by hardware, cleared by software.
// Assumes: a set and a clear in the same cycle resolve to set.
module usb_isr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_set,
    input  logic sw_clr,
    output logic q
);
    // Hold the bit; set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= 1'b0;
        else if (hw_set) q <= 1'b1;
        else if (sw_clr) q <= 1'b0;
    end
endmodule

// File: rtl/usb_isr_ctr_sum.sv
// Module: live correct-transfer summary over all endpoint flags.
// Assumes: the flags are levels held in endpoint registers elsewhere.
module usb_isr_ctr_sum #(
    parameter int NUM_EP = 3
) (
    input  logic              ep0_ctr,
    input  logic [NUM_EP-1:0] epn_rx_ctr,
    input  logic [NUM_EP-1:0] epn_tx_ctr,
    output logic              ctr_any
);
    // Reduce every source flag into one level.
    always_comb ctr_any = ep0_ctr | (|epn_rx_ctr) | (|epn_tx_ctr);
endmodule

// File: rtl/usb_isr_ovr_detect.sv
// Module: setup-overrun detection and transfer-info update gating.
// Assumes: ep0_ctr shows the flag before this transfer would set it.
module usb_isr_ovr_detect (
    input  logic xfer_done,
    input  logic xfer_setup,
    input  logic ep0_ctr,
    output logic ovr_evt,
    output logic info_upd
);
    // A SETUP landing on a still-pending control endpoint is an overrun.
    always_comb ovr_evt = xfer_done & xfer_setup & ep0_ctr;
    // Transfer info is refreshed for every completion except an overrun.
    always_comb info_upd = xfer_done & ~ovr_evt;
endmodule

// File: rtl/usb_isr_irq_mask.sv
// Module: mask register and combined interrupt request.
// Assumes: the mask is written whole; any masked-in status bit requests.
module usb_isr_irq_mask #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mask_wr,
    input  logic [W-1:0] mask_wdata,
    input  logic [W-1:0] status,
    output logic [W-1:0] mask,
    output logic         irq
);
    // Load the mask on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (mask_wr) mask <= mask_wdata;
    end
    // Combine enabled status bits into one request.
    always_comb irq = |(status & mask);
endmodule

// File: rtl/usb_irq_status_agg.sv
// Module: USB device interrupt status byte with overrun detection.
// Assumes: event inputs are single-cycle pulses; writes clear on zero.
module usb_irq_status_agg #(
    parameter int NUM_EP = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_sof,
    input  logic              ev_bus_reset,
    input  logic              ev_resume,
    input  logic              ev_suspend,
    input  logic              ev_error,
    input  logic              xfer_done,
    input  logic              xfer_setup,
    input  logic              ep0_ctr,
    input  logic [NUM_EP-1:0] epn_rx_ctr,
    input  logic [NUM_EP-1:0] epn_tx_ctr,
    input  logic              st_wr,
    input  logic [7:0]        st_wdata,
    input  logic              mask_wr,
    input  logic [7:0]        mask_wdata,
    output logic [7:0]        status,
    output logic [7:0]        mask,
    output logic              info_upd,
    output logic              irq
);
    import usb_isr_pkg::*;

    logic                ovr_evt;
    logic                ctr_any;
    logic [STICKY_W-1:0] set_vec;
    logic [STICKY_W-1:0] clr_vec;
    logic [STICKY_W-1:0] sticky_q;

    usb_isr_ovr_detect ovr_i (
        .xfer_done  (xfer_done),
        .xfer_setup (xfer_setup),
        .ep0_ctr    (ep0_ctr),
        .ovr_evt    (ovr_evt),
        .info_upd   (info_upd)
    );

    usb_isr_ctr_sum #(.NUM_EP(NUM_EP)) sum_i (
        .ep0_ctr    (ep0_ctr),
        .epn_rx_ctr (epn_rx_ctr),
        .epn_tx_ctr (epn_tx_ctr),
        .ctr_any    (ctr_any)
    );

    // Route each hardware event to its status position.
    always_comb begin
        set_vec            = '0;
        set_vec[B_SOF]     = ev_sof;
        set_vec[B_BUSRST]  = ev_bus_reset;
        set_vec[B_RESUME]  = ev_resume;
        set_vec[B_SUSPEND] = ev_suspend;
        set_vec[B_ERROR]   = ev_error;
        set_vec[B_OVR]     = ovr_evt;
    end

    // A write clears every sticky position written with zero.
    always_comb clr_vec = {STICKY_W{st_wr}} & ~st_wdata[STICKY_W-1:0];

    for (genvar i = 0; i < STICKY_W; i++) begin : g_flag
        usb_isr_flag flag_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .hw_set (set_vec[i]),
            .sw_clr (clr_vec[i]),
            .q      (sticky_q[i])
        );
    end

    // Assemble the visible status byte.
    always_comb begin
        status                 = '0;
        status[STICKY_W-1:0]   = sticky_q;
        status[B_ZERO]         = 1'b0;
        status[B_CTR]          = ctr_any;
    end

    usb_isr_irq_mask #(.W(STW)) irq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask_wr    (mask_wr),
        .mask_wdata (mask_wdata),
        .status     (status),
        .mask       (mask),
        .irq        (irq)
    );
endmodule

// File: rtl/usb_irq_status_agg_chk.sv
// Module: protocol checker for the interrupt status aggregator.
// Assumes: bound onto usb_irq_status_agg; sees its ports only.
module usb_irq_status_agg_chk #(
    parameter int NUM_EP = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_sof,
    input logic              ev_bus_reset,
    input logic              xfer_done,
    input logic              xfer_setup,
    input logic              ep0_ctr,
    input logic [NUM_EP-1:0] epn_rx_ctr,
    input logic [NUM_EP-1:0] epn_tx_ctr,
    input logic              st_wr,
    input logic [7:0]        st_wdata,
    input logic [7:0]        status,
    input logic [7:0]        mask,
    input logic              info_upd,
    input logic              irq
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (status[5:0] == 6'h00 && mask == 8'h00));
    // R2
    sof_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_sof |=> status[0]);
    // R3
    no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[1] && !ev_bus_reset) |=> !status[1]);
    // R3
    zero_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && !st_wdata[0] && !ev_sof) |=> !status[0]);
    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_bus_reset && st_wr && !st_wdata[1]) |=> status[1]);
    // R5
    ctr_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[7] == (ep0_ctr || (|epn_rx_ctr) || (|epn_tx_ctr)));
    // R6
    bit6_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !status[6]);
    // R7
    ovr_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && xfer_setup && ep0_ctr) |=> status[5]);
    // R8
    info_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && xfer_setup && ep0_ctr) |-> !info_upd);
    // R8
    info_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !(xfer_setup && ep0_ctr)) |-> info_upd);
    // R9
    irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & mask) == 8'h00) |-> !irq);
endmodule

bind usb_irq_status_agg usb_irq_status_agg_chk #(.NUM_EP(NUM_EP)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_sof       (ev_sof),
    .ev_bus_reset (ev_bus_reset),
    .xfer_done    (xfer_done),
    .xfer_setup   (xfer_setup),
    .ep0_ctr      (ep0_ctr),
    .epn_rx_ctr   (epn_rx_ctr),
    .epn_tx_ctr   (epn_tx_ctr),
    .st_wr        (st_wr),
    .st_wdata     (st_wdata),
    .status       (status),
    .mask         (mask),
    .info_upd     (info_upd),
    .irq          (irq)
);

// File: tb/usb_irq_status_agg_tb.sv
// Bench: sweeps of events, endpoint flags, overrun cases and masks.
module usb_irq_status_agg_tb_top;
    localparam int NUM_EP = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ev_sof = 0, ev_bus_reset = 0, ev_resume = 0;
    logic              ev_suspend = 0, ev_error = 0;
    logic              xfer_done = 0, xfer_setup = 0, ep0_ctr = 0;
    logic [NUM_EP-1:0] epn_rx_ctr = '0, epn_tx_ctr = '0;
    logic              st_wr = 0, mask_wr = 0;
    logic [7:0]        st_wdata = '0, mask_wdata = '0;
    logic [7:0]        status, mask;
    logic              info_upd, irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    usb_irq_status_agg #(.NUM_EP(NUM_EP)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .ev_sof(ev_sof), .ev_bus_reset(ev_bus_reset), .ev_resume(ev_resume),
        .ev_suspend(ev_suspend), .ev_error(ev_error),
        .xfer_done(xfer_done), .xfer_setup(xfer_setup), .ep0_ctr(ep0_ctr),
        .epn_rx_ctr(epn_rx_ctr), .epn_tx_ctr(epn_tx_ctr),
        .st_wr(st_wr), .st_wdata(st_wdata),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .status(status), .mask(mask), .info_upd(info_upd), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one cycle of stimulus at a falling edge, then idle inputs.
    task automatic step();
        @(negedge clk);
        ev_sof = 0; ev_bus_reset = 0; ev_resume = 0; ev_suspend = 0; ev_error = 0;
        xfer_done = 0; xfer_setup = 0; st_wr = 0; mask_wr = 0;
    endtask

    task automatic clear_all();
        st_wr = 1; st_wdata = 8'h00;
        step();
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] exp8;
        logic       ex1;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 status", status, 8'h00);
        chk("R1 mask", mask, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        rst_n = 1;
        @(negedge clk);

        // R2/R3/R7: every event combination, then a partial clear
        for (int p = 0; p < 64; p++) begin
            clear_all();
            ev_sof = p[0]; ev_bus_reset = p[1]; ev_resume = p[2];
            ev_suspend = p[3]; ev_error = p[4];
            xfer_done = p[5]; xfer_setup = p[5]; ep0_ctr = p[5];
            step();
            ep0_ctr = 0;
            #1;
            chk("R2 R7 events set", status, {2'b00, p[5:0]});
            st_wr = 1; st_wdata = {2'b11, p[5:0] ^ 6'h2A};
            step();
            chk("R3 clear on zero", status, {2'b00, p[5:0] & (p[5:0] ^ 6'h2A)});
            // writing ones never sets
            st_wr = 1; st_wdata = 8'hFF;
            step();
            chk("R3 ones hold", status, {2'b00, p[5:0] & (p[5:0] ^ 6'h2A)});
        end

        // R4: all sets collide with a clear-all write
        clear_all();
        ev_sof = 1; ev_bus_reset = 1; ev_resume = 1; ev_suspend = 1; ev_error = 1;
        xfer_done = 1; xfer_setup = 1; ep0_ctr = 1;
        st_wr = 1; st_wdata = 8'h00;
        step();
        ep0_ctr = 0;
        #1;
        chk("R4 set wins", status, 8'h3F);

        // R5/R6: every endpoint flag combination with a clearing write
        clear_all();
        for (int f = 0; f < 128; f++) begin
            ep0_ctr = f[0]; epn_rx_ctr = f[3:1]; epn_tx_ctr = f[6:4];
            st_wr = 1; st_wdata = 8'h00;
            #1;
            ex1 = (f != 0);
            chk("R5 summary", {7'd0, status[7]}, {7'd0, ex1});
            chk("R6 bit6", {7'd0, status[6]}, 8'h00);
            step();
            chk("R5 write no effect", {7'd0, status[7]}, {7'd0, ex1});
        end
        ep0_ctr = 0; epn_rx_ctr = '0; epn_tx_ctr = '0;

        // R7/R8: all completion, setup and pending combinations
        for (int c = 0; c < 8; c++) begin
            clear_all();
            xfer_done = c[0]; xfer_setup = c[1]; ep0_ctr = c[2];
            #1;
            ex1 = c[0] && !(c[1] && c[2]);
            chk("R8 info_upd", {7'd0, info_upd}, {7'd0, ex1});
            step();
            ep0_ctr = 0;
            #1;
            ex1 = c[0] && c[1] && c[2];
            chk("R7 overrun", {7'd0, status[5]}, {7'd0, ex1});
        end

        // R9: every mask against two complementary status patterns
        for (int ph = 0; ph < 2; ph++) begin
            clear_all();
            if (ph == 0) begin ev_sof = 1; ev_resume = 1; ev_error = 1; end
            else begin ev_bus_reset = 1; ev_suspend = 1; xfer_done = 1; xfer_setup = 1; ep0_ctr = 1; end
            step();
            ep0_ctr = (ph == 1);
            for (int m = 0; m < 256; m++) begin
                mask_wr = 1; mask_wdata = m[7:0];
                step();
                exp8 = (ph == 0) ? 8'h15 : 8'hAA;
                chk("R9 mask", mask, m[7:0]);
                chk("R9 irq", {7'd0, irq}, {7'd0, |(exp8 & m[7:0])});
            end
            ep0_ctr = 0;
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule